// File: doc/BRIEF.md
# Lookup-Style 8-bit Multi-Function ALU

This block is a purely combinational arithmetic and logic unit with 32 operations. A 5-bit operation code selects the operation. It reads two data operands, `a` and `b`, and a carry input. It returns a data result and four flags: carry, zero, negative and overflow. The operations cover plain and carry-aware add and subtract, negation and increment, the high and low halves of a product, binary divide and remainder, decimal divide and remainder of a 16-bit value by ten, shifts, rotates through carry, bitwise logic, and packed-decimal add and subtract.

The block is written as a behavioural equivalent of an ALU held in a lookup table. Every output is a pure function of `{op, cin, a, b}`, so the unit can be swept input by input and compared against a table. A surrounding datapath decodes instructions and stores the flags; neither of those jobs is part of this block.

Top module: `alu_rom8`

## Requirements
- R1: Codes 0 to 7 give, in that order: 0, a, b, two's complement of a, two's complement of b, the low byte of ({b,a} / 10), ({b,a} mod 10), and b+1. Here {b,a} is the 16-bit value with b as the upper byte.
- R2: Codes 8 to 12 give, in that order: b-1, a+b, a-b, b-a, and a-b. For code 12, carry is set when a >= b, unsigned.
- R3: When cin=1, codes 13, 14 and 15 give a+b+1, a-b-1 and b-a-1. When cin=0, their result and all four flags equal those of codes 9, 10 and 11 for the same operands.
- R4: Code 16 gives the upper byte of the unsigned product a*b, and code 17 gives its lower byte. Code 18 gives the unsigned quotient a/b, and code 19 gives the remainder a mod b.
- R5: Codes 18 and 19 with b=0 give result 0, overflow 1 and carry 0.
- R6: Codes 20, 21 and 22 give a shifted by b[2:0]: left, arithmetic right, and logical right. Carry is the last bit shifted out, or 0 when the amount is 0.
- R7: Codes 23 and 24 rotate the 9-bit value {cin, a} by b[2:0], to the left and to the right respectively. The result is the lower 8 bits and carry is bit 8.
- R8: Codes 25 to 29 give, in that order: a AND b, a OR b, a XOR b, NOT(a AND b), and NOT b.
- R9: Codes 30 and 31 add and subtract a and b as two packed decimal digits. A digit sum above 9 is corrected by +6 and carries one digit up. A negative digit difference is corrected by +10 and borrows one digit up. Carry is the decimal carry out of the top digit for add, or the borrow out of it for subtract.
- R10: Carry holds the ninth sum bit for addition (codes 7, 9, 13) and the borrow for subtraction (codes 3, 4, 8, 10, 11, 14, 15). Carry is 0 for every code not named in R2, R5, R6, R7, R9 or here.
- R11: Zero is 1 exactly when the result is 0. Negative equals bit 7 of the result.
- R12: For codes 9 to 15, overflow is signed two's-complement overflow of the operation. For any other code, overflow is 0, except in the case that R5 defines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 5 | Operation code, 0 to 31 |
| a | input | 8 | Left operand |
| b | input | 8 | Right operand; its low 3 bits set the shift amount |
| cin | input | 1 | Carry input for codes 13 to 15, 23 and 24 |
| result | output | 8 | Data result |
| cout | output | 1 | Carry or borrow flag |
| zero | output | 1 | Result-is-zero flag |
| neg | output | 1 | Copy of the result sign bit |
| ovf | output | 1 | Signed overflow or divide-by-zero flag |

## Verification
The checker evaluates its properties only while every input is at a known 0 or 1, because a lookup-style unit has no meaningful output for unknown inputs. The bench therefore drives all inputs from its first cycle onward. The decimal-digit property holds only when both operands are valid packed decimal, so it is gated on that condition. The stimulus mixes in-range decimal pairs with arbitrary bytes, so the gate is both exercised and skipped. Zero divisors, shift amounts of 0 and 7, and sign-boundary operands are applied directly, and random vectors cover the rest.

// File: rtl/alu_rom8_pkg.sv
package alu_rom8_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ZERO  = 5'd0,  OP_PASSA = 5'd1,  OP_PASSB = 5'd2,  OP_NEGA  = 5'd3,
    OP_NEGB  = 5'd4,  OP_DDIV  = 5'd5,  OP_DMOD  = 5'd6,  OP_INCB  = 5'd7,
    OP_DECB  = 5'd8,  OP_ADD   = 5'd9,  OP_SUBAB = 5'd10, OP_SUBBA = 5'd11,
    OP_CMPAB = 5'd12, OP_ADDC  = 5'd13, OP_SUBABC= 5'd14, OP_SUBBAC= 5'd15,
    OP_MULHI = 5'd16, OP_MULLO = 5'd17, OP_DIV   = 5'd18, OP_MOD   = 5'd19,
    OP_SHL   = 5'd20, OP_SAR   = 5'd21, OP_SHR   = 5'd22, OP_RLC   = 5'd23,
    OP_RRC   = 5'd24, OP_AND   = 5'd25, OP_OR    = 5'd26, OP_XOR   = 5'd27,
    OP_NAND  = 5'd28, OP_NOTB  = 5'd29, OP_BCDADD= 5'd30, OP_BCDSUB= 5'd31
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_rom8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           carry,
  output logic           ovf
);
  logic [W-1:0] x, y;
  logic         k, is_sub, cmp_mode, ovf_en;
  logic [W:0]   wide;

  // operand routing per code
  always_comb begin
    x = '0; y = '0; k = 1'b0; is_sub = 1'b0; cmp_mode = 1'b0; ovf_en = 1'b0;
    unique case (op)
      OP_NEGA:   begin x = '0; y = a; is_sub = 1'b1; end
      OP_NEGB:   begin x = '0; y = b; is_sub = 1'b1; end
      OP_INCB:   begin x = b; y = W'(1); end
      OP_DECB:   begin x = b; y = W'(1); is_sub = 1'b1; end
      OP_ADD:    begin x = a; y = b; ovf_en = 1'b1; end
      OP_SUBAB:  begin x = a; y = b; is_sub = 1'b1; ovf_en = 1'b1; end
      OP_SUBBA:  begin x = b; y = a; is_sub = 1'b1; ovf_en = 1'b1; end
      OP_CMPAB:  begin x = a; y = b; is_sub = 1'b1; ovf_en = 1'b1; cmp_mode = 1'b1; end
      OP_ADDC:   begin x = a; y = b; k = cin; ovf_en = 1'b1; end
      OP_SUBABC: begin x = a; y = b; k = cin; is_sub = 1'b1; ovf_en = 1'b1; end
      OP_SUBBAC: begin x = b; y = a; k = cin; is_sub = 1'b1; ovf_en = 1'b1; end
      default:   ;
    endcase
  end

  // shared adder / subtractor
  always_comb begin
    if (is_sub) wide = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, k};
    else        wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, k};
    res   = wide[W-1:0];
    carry = cmp_mode ? ~wide[W] : wide[W];
    if (!ovf_en)     ovf = 1'b0;
    else if (is_sub) ovf = (x[W-1] != y[W-1]) && (res[W-1] != x[W-1]);
    else             ovf = (x[W-1] == y[W-1]) && (res[W-1] != x[W-1]);
  end
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] mul_hi,
  output logic [W-1:0] mul_lo,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         div_zero,
  output logic [W-1:0] dec_quo,
  output logic [W-1:0] dec_rem
);
  localparam int PW = 2 * W;
  localparam logic [PW-1:0] TEN = PW'(10);

  logic [PW-1:0] prod, joined, dq, dr;

  always_comb begin
    prod     = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    mul_hi   = prod[PW-1:W];
    mul_lo   = prod[W-1:0];
    div_zero = (b == '0);
    quo      = div_zero ? '0 : (a / b);
    rem      = div_zero ? '0 : (a % b);
    joined   = {b, a};
    dq       = joined / TEN;
    dr       = joined % TEN;
    dec_quo  = dq[W-1:0];
    dec_rem  = dr[W-1:0];
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_rom8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         carry
);
  localparam int SW = $clog2(W);
  localparam int RW = W + 1;

  logic [SW-1:0] amt;
  logic [W:0]    tl, tr, ta, ring, rl, rr;

  always_comb begin
    amt  = b[SW-1:0];
    tl   = {1'b0, a} << amt;
    tr   = {a, 1'b0} >> amt;
    ta   = $unsigned($signed({a, 1'b0}) >>> amt);
    ring = {cin, a};
    rl   = (ring << amt) | (ring >> (RW - int'(amt)));
    rr   = (ring >> amt) | (ring << (RW - int'(amt)));
    res   = '0;
    carry = 1'b0;
    unique case (op)
      OP_SHL: begin res = tl[W-1:0]; carry = tl[W]; end
      OP_SAR: begin res = ta[W:1];   carry = ta[0]; end
      OP_SHR: begin res = tr[W:1];   carry = tr[0]; end
      OP_RLC: begin res = rl[W-1:0]; carry = rl[W]; end
      OP_RRC: begin res = rr[W-1:0]; carry = rr[W]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_bcd.sv
module alu_bcd #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         sum_carry,
  output logic [W-1:0] diff,
  output logic         diff_borrow
);
  localparam int DIGITS = W / 4;

  logic [DIGITS:0] cy, bw;
  assign cy[0] = 1'b0;
  assign bw[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [5:0] s_raw, s_fix;
    logic signed [5:0] d_raw, d_fix;
    always_comb begin
      s_raw = {2'b00, a[4*g +: 4]} + {2'b00, b[4*g +: 4]} + {5'b0, cy[g]};
      d_raw = $signed({2'b00, a[4*g +: 4]}) - $signed({2'b00, b[4*g +: 4]})
              - $signed({5'b0, bw[g]});
      s_fix = (s_raw > 6'd9) ? s_raw + 6'd6 : s_raw;
      d_fix = (d_raw < 0) ? d_raw + 6'sd10 : d_raw;
    end
    assign cy[g+1]         = (s_raw > 6'd9);
    assign bw[g+1]         = (d_raw < 0);
    assign sum[4*g +: 4]   = s_fix[3:0];
    assign diff[4*g +: 4]  = d_fix[3:0];
  end

  assign sum_carry   = cy[DIGITS];
  assign diff_borrow = bw[DIGITS];
endmodule

// File: rtl/alu_rom8.sv
module alu_rom8
  import alu_rom8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   result,
  output logic           cout,
  output logic           zero,
  output logic           neg,
  output logic           ovf
);
  alu_op_e      op_e;
  logic [W-1:0] as_res, sh_res, mul_hi, mul_lo, quo, rem, dq, dr, bsum, bdiff;
  logic         as_c, as_v, sh_c, dz, bsum_c, bdiff_b;

  assign op_e = alu_op_e'(op);

  alu_addsub #(.W(W)) u_addsub (
    .op(op_e), .a(a), .b(b), .cin(cin), .res(as_res), .carry(as_c), .ovf(as_v)
  );

  alu_muldiv #(.W(W)) u_muldiv (
    .a(a), .b(b), .mul_hi(mul_hi), .mul_lo(mul_lo), .quo(quo), .rem(rem),
    .div_zero(dz), .dec_quo(dq), .dec_rem(dr)
  );

  alu_shift #(.W(W)) u_shift (
    .op(op_e), .a(a), .b(b), .cin(cin), .res(sh_res), .carry(sh_c)
  );

  alu_bcd #(.W(W)) u_bcd (
    .a(a), .b(b), .sum(bsum), .sum_carry(bsum_c), .diff(bdiff), .diff_borrow(bdiff_b)
  );

  // result and carry selection
  always_comb begin
    result = '0;
    cout   = 1'b0;
    ovf    = 1'b0;
    unique case (op_e)
      OP_ZERO:  result = '0;
      OP_PASSA: result = a;
      OP_PASSB: result = b;
      OP_DDIV:  result = dq;
      OP_DMOD:  result = dr;
      OP_NEGA, OP_NEGB, OP_INCB, OP_DECB, OP_ADD, OP_SUBAB, OP_SUBBA,
      OP_CMPAB, OP_ADDC, OP_SUBABC, OP_SUBBAC: begin
        result = as_res; cout = as_c; ovf = as_v;
      end
      OP_MULHI: result = mul_hi;
      OP_MULLO: result = mul_lo;
      OP_DIV:   begin result = quo; ovf = dz; end
      OP_MOD:   begin result = rem; ovf = dz; end
      OP_SHL, OP_SAR, OP_SHR, OP_RLC, OP_RRC: begin
        result = sh_res; cout = sh_c;
      end
      OP_AND:    result = a & b;
      OP_OR:     result = a | b;
      OP_XOR:    result = a ^ b;
      OP_NAND:   result = ~(a & b);
      OP_NOTB:   result = ~b;
      OP_BCDADD: begin result = bsum;  cout = bsum_c;  end
      OP_BCDSUB: begin result = bdiff; cout = bdiff_b; end
      default: ;
    endcase
  end

  assign zero = ~|result;
  assign neg  = result[W-1];
endmodule

// File: rtl/alu_rom8_chk.sv
module alu_rom8_chk #(
  parameter int W = 8
) (
  input logic [4:0]   op,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         cin,
  input logic [W-1:0] result,
  input logic         cout,
  input logic         zero,
  input logic         neg,
  input logic         ovf
);
  logic known, is_div, a_bcd, b_bcd, r_bcd;

  always_comb begin
    known  = !$isunknown({op, a, b, cin});
    is_div = (op == 5'd18) || (op == 5'd19);
    a_bcd = 1'b1; b_bcd = 1'b1; r_bcd = 1'b1;
    for (int i = 0; i < W / 4; i++) begin
      if (a[4*i +: 4] > 4'd9)      a_bcd = 1'b0;
      if (b[4*i +: 4] > 4'd9)      b_bcd = 1'b0;
      if (result[4*i +: 4] > 4'd9) r_bcd = 1'b0;
    end
  end

  always_comb begin
    if (known) begin
      // R11
      zero_flag_chk: assert (zero == (result == '0));
      // R11
      neg_flag_chk: assert (neg == result[W-1]);
      // R5
      div_zero_chk: assert (!(is_div && b == '0) || (result == '0 && ovf && !cout));
      // R12
      ovf_scope_chk: assert (!ovf || (op >= 5'd9 && op <= 5'd15) || (is_div && b == '0));
      // R1
      pass_a_chk: assert (op != 5'd1 || (result == a && !cout && !ovf));
      // R9
      bcd_digit_chk: assert (!((op == 5'd30 || op == 5'd31) && a_bcd && b_bcd) || r_bcd);
    end
  end
endmodule

bind alu_rom8 alu_rom8_chk #(.W(W)) u_chk (
  .op(op), .a(a), .b(b), .cin(cin), .result(result),
  .cout(cout), .zero(zero), .neg(neg), .ovf(ovf)
);

// File: tb/sim_alu_rom8.sv
module sim_alu_rom8;
  localparam int W = 8;

  logic clk, rst_n;
  logic [4:0]   op;
  logic [W-1:0] a, b;
  logic         cin;
  logic [W-1:0] result;
  logic         cout, zero, neg, ovf;

  int errors = 0;
  int checks = 0;

  alu_rom8 #(.W(W)) u0 (
    .op(op), .a(a), .b(b), .cin(cin), .result(result),
    .cout(cout), .zero(zero), .neg(neg), .ovf(ovf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [7:0] r;
    logic c, z, n, v;
  } exp_t;

  function automatic string req_of(int o);
    if (o <= 7)  return "R1";
    if (o <= 12) return "R2";
    if (o <= 15) return "R3";
    if (o <= 19) return "R4";
    if (o <= 22) return "R6";
    if (o <= 24) return "R7";
    if (o <= 29) return "R8";
    return "R9";
  endfunction

  function automatic exp_t model(int o, int x, int y, int ci);
    exp_t e;
    int r = 0, c = 0, v = 0, s, t, sx;
    s = y & 7;
    case (o)
      0: r = 0;
      1: r = x;
      2: r = y;
      3: begin r = (0 - x) & 255; c = (x != 0); end  // R10
      4: begin r = (0 - y) & 255; c = (y != 0); end
      5: r = ((y * 256 + x) / 10) & 255;
      6: r = (y * 256 + x) % 10;
      7: begin r = (y + 1) & 255; c = (y == 255); end
      8: begin r = (y - 1) & 255; c = (y == 0); end
      9, 13: begin
        t = x + y + ((o == 13) ? ci : 0);
        r = t & 255; c = t >> 8;
        v = (((x ^ y) & 128) == 0) && (((r ^ x) & 128) != 0);  // R12
      end
      10, 12, 14: begin
        t = (o == 14) ? ci : 0;
        r = (x - y - t) & 255;
        c = (o == 12) ? (x >= y) : (x < y + t);
        v = (((x ^ y) & 128) != 0) && (((r ^ x) & 128) != 0);
      end
      11, 15: begin
        t = (o == 15) ? ci : 0;
        r = (y - x - t) & 255;
        c = (y < x + t);
        v = (((x ^ y) & 128) != 0) && (((r ^ y) & 128) != 0);
      end
      16: r = (x * y) >> 8;
      17: r = (x * y) & 255;
      18: if (y == 0) v = 1; else r = x / y;  // R5
      19: if (y == 0) v = 1; else r = x % y;
      20: begin t = x << s; r = t & 255; c = (s != 0) ? ((t >> 8) & 1) : 0; end
      21: begin
        sx = (x >= 128) ? x - 256 : x;
        r = (sx >>> s) & 255; c = (s != 0) ? ((x >> (s - 1)) & 1) : 0;
      end
      22: begin r = x >> s; c = (s != 0) ? ((x >> (s - 1)) & 1) : 0; end
      23: begin
        r = x; c = ci;
        for (int i = 0; i < s; i++) begin
          t = (r >> 7) & 1; r = ((r << 1) | c) & 255; c = t;
        end
      end
      24: begin
        r = x; c = ci;
        for (int i = 0; i < s; i++) begin
          t = r & 1; r = (r >> 1) | (c << 7); c = t;
        end
      end
      25: r = x & y;
      26: r = x | y;
      27: r = x ^ y;
      28: r = (~(x & y)) & 255;
      29: r = (~y) & 255;
      30: begin
        t = 0;
        for (int d = 0; d < 2; d++) begin
          sx = ((x >> (4 * d)) & 15) + ((y >> (4 * d)) & 15) + t;
          if (sx > 9) begin sx = sx + 6; t = 1; end else t = 0;
          r = r | ((sx & 15) << (4 * d));
        end
        c = t;
      end
      default: begin
        t = 0;
        for (int d = 0; d < 2; d++) begin
          sx = ((x >> (4 * d)) & 15) - ((y >> (4 * d)) & 15) - t;
          if (sx < 0) begin sx = sx + 10; t = 1; end else t = 0;
          r = r | ((sx & 15) << (4 * d));
        end
        c = t;
      end
    endcase
    e.r = r[7:0]; e.c = c[0]; e.v = v[0];
    e.z = (r == 0);  // R11
    e.n = r[7];
    return e;
  endfunction

  task automatic apply(int o, int x, int y, int ci);
    @(posedge clk);
    op = o[4:0]; a = x[7:0]; b = y[7:0]; cin = ci[0];
    @(negedge clk);
  endtask

  task automatic check_vec(int o, int x, int y, int ci);
    exp_t e;
    apply(o, x, y, ci);
    e = model(o, x, y, ci);
    checks++;
    if ({result, cout, zero, neg, ovf} !== {e.r, e.c, e.z, e.n, e.v}) begin
      errors++;
      $display("FAIL %s op=%0d a=%02h b=%02h cin=%0d actual r=%02h c%0b z%0b n%0b v%0b expected r=%02h c%0b z%0b n%0b v%0b",
               req_of(o), o, x, y, ci, result, cout, zero, neg, ovf,
               e.r, e.c, e.z, e.n, e.v);
    end
  endtask

  // R3: fallback form compared port to port against the plain code
  task automatic check_fallback(int o, int x, int y);
    logic [11:0] plain;
    apply(o - 4, x, y, 0);
    plain = {result, cout, zero, neg, ovf};
    apply(o, x, y, 0);
    checks++;
    if ({result, cout, zero, neg, ovf} !== plain) begin
      errors++;
      $display("FAIL R3 op=%0d a=%02h b=%02h cin=0 actual=%03h expected=%03h",
               o, x, y, {result, cout, zero, neg, ovf}, plain);
    end
  endtask

  initial begin
    op = '0; a = '0; b = '0; cin = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R11: idle state after reset, code 0
    checks++;
    if ({result, cout, zero, neg, ovf} !== {8'h00, 1'b0, 1'b1, 1'b0, 1'b0}) begin
      errors++;
      $display("FAIL R1 idle actual=%03h expected=%03h", {result, cout, zero, neg, ovf}, 12'h004);
    end
  end

  initial begin : main
    int corners[8] = '{0, 1, 7, 8'h7f, 8'h80, 8'h99, 8'hfe, 8'hff};
    @(posedge rst_n);
    repeat (2) @(posedge clk);
    // directed corners over every code, both carry-in values (R1..R12)
    for (int o = 0; o < 32; o++)
      for (int ci = 0; ci < 2; ci++)
        foreach (corners[i])
          foreach (corners[j])
            check_vec(o, corners[i], corners[j], ci);
    // R5: zero divisor
    for (int x = 0; x < 256; x += 37) begin
      check_vec(18, x, 0, 1);
      check_vec(19, x, 0, 0);
    end
    // R6 R7: every shift amount
    for (int s = 0; s < 8; s++)
      for (int o = 20; o <= 24; o++) begin
        check_vec(o, 8'hb5, s, 1);
        check_vec(o, 8'h4a, 8'hf8 | s, 0);
      end
    // R3: fallback equivalence
    foreach (corners[i])
      foreach (corners[j])
        for (int o = 13; o <= 15; o++)
          check_fallback(o, corners[i], corners[j]);
    // random sweep, fixed seed; R9 with valid decimal half the time
    void'($urandom(32'd20250));
    for (int k = 0; k < 20000; k++) begin
      int o = $urandom_range(31);
      int x = $urandom_range(255);
      int y = $urandom_range(255);
      if (o >= 30 && $urandom_range(1) == 1) begin
        x = $urandom_range(9) * 16 + $urandom_range(9);
        y = $urandom_range(9) * 16 + $urandom_range(9);
      end
      check_vec(o, x, y, $urandom_range(1));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule